// File: doc/BRIEF.md
# Data Address Generator for a Signal-Processing Core

This block turns the operand fields of a load or store into data-memory addresses. In one cycle it serves one of three direct forms or an indirect form. The direct forms are a paged data access, a stack-relative access and a peripheral-space access. The indirect form reads one of eight address pointers, or two of them in dual mode. A separate coefficient pointer can add a further operand address in the same cycle. The address outputs follow the request inputs within the same cycle. Pointer post-modification is written into the block's own pointer registers at the next rising clock edge.

Each indirect lane may leave its pointer unchanged or step it up or down by one. A step may be linear, or it may wrap inside a circular buffer. Each buffer is set by a start value and a size. Pointers 0 to 3 share one start/size pair, pointers 4 to 7 share a second pair, and the coefficient pointer has a third. A load port writes any pointer directly, for example when a loop is set up. If the two dual lanes name the same pointer, the request is flagged as a conflict.

Top module: `dag_top`

## Requirements
- R1: While `rst` is high, all nine pointers clear to zero, and they read zero on the first cycle after reset is released.
- R2: With `mode`=0 (paged data), `addr_a` = {`dp_pg`[7:0], low 15 bits of (`dp` + `offset`)} and `a_valid` is 1.
- R3: With `mode`=1 (stack), `addr_a` = {`sp_pg`[7:0], low 15 bits of (`sp` + `offset`)} and `a_valid` is 1.
- R4: With `mode`=2 (peripheral), `io_addr` = {`io_pg`[9:0], `offset`[5:0]}, `io_valid` is 1, and `a_valid` and `b_valid` are 0.
- R5: With `mode`=3 (single indirect), `addr_a` = {`ptr_pg`, pointer[`sel_a`]} using the pointer value before any modification. Mode values 5 to 7, and cycles with `req_valid` low, raise no valid and zero every address.
- R6: Modify code 1 adds one and code 2 subtracts one, both modulo 2^16. Code 0 leaves the pointer unchanged. The new value appears only after the next rising edge. With no request and no load, no pointer changes.
- R7: Modify code 3 (circular up) gives pointer+1, except that a result equal to start+size becomes start.
- R8: Modify code 4 (circular down) gives pointer-1, except that a pointer equal to start becomes start+size-1.
- R9: Circular steps on pointers 0 to 3 use `cb_start`/`cb_size` slice 0, pointers 4 to 7 use slice 1, and the coefficient pointer uses slice 2. Slice g occupies bits [16g+15:16g].
- R10: With `mode`=4 (dual), `addr_a` and `addr_b` come from pointers `sel_a` and `sel_b` in the same cycle, and each pointer takes its own modify code.
- R11: With `coef_en`=1 and `req_valid`=1, `addr_c` = {`ptr_pg`, coefficient pointer} and `c_valid` is 1 in any mode. The coefficient pointer is then stepped by `mod_c`.
- R12: In dual mode with `sel_a`=`sel_b`, `conflict` is 1 and neither dual lane changes a pointer.
- R13: With `ld_en`=1, the pointer indexed by `ld_sel` (0 to 7 address pointers, 8 coefficient) takes `ld_val` at the next edge. This overrides any modification of that pointer in the same cycle. `ld_sel` values 9 to 15 write nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An access is requested this cycle |
| mode | input | 3 | 0 paged, 1 stack, 2 peripheral, 3 indirect, 4 dual indirect |
| offset | input | 7 | Offset field from the instruction |
| sel_a | input | 3 | Pointer for lane A |
| mod_a | input | 3 | Modify code for lane A |
| sel_b | input | 3 | Pointer for lane B (dual mode) |
| mod_b | input | 3 | Modify code for lane B |
| coef_en | input | 1 | Coefficient operand requested |
| mod_c | input | 3 | Modify code for the coefficient pointer |
| dp_pg | input | 8 | High bits of the data page |
| dp | input | 16 | Data page base |
| sp_pg | input | 8 | High bits of the stack page |
| sp | input | 16 | Stack pointer |
| io_pg | input | 10 | Peripheral page |
| ptr_pg | input | 7 | Upper bits for indirect addresses |
| cb_start | input | 48 | Three circular buffer starts |
| cb_size | input | 48 | Three circular buffer sizes |
| ld_en | input | 1 | Pointer load strobe |
| ld_sel | input | 4 | Pointer to load |
| ld_val | input | 16 | Value to load |
| addr_a | output | 23 | Lane A / direct address |
| a_valid | output | 1 | addr_a is valid |
| addr_b | output | 23 | Lane B address |
| b_valid | output | 1 | addr_b is valid |
| addr_c | output | 23 | Coefficient address |
| c_valid | output | 1 | addr_c is valid |
| io_addr | output | 16 | Peripheral address |
| io_valid | output | 1 | io_addr is valid |
| conflict | output | 1 | Both dual lanes name the same pointer |
| ptr_flat | output | 144 | Pointers 0..7 then the coefficient pointer, 16 bits each |

## Verification
Some rules are checked by assertions on every cycle. These cover the conflict flag for matching dual selects, and that a conflicting lane pointer keeps its value. They also cover that pointers stay still with no request and no load, that a peripheral access never comes with a data address, that lane B is never valid without lane A, and that pointers read zero after reset. The bench's scenarios must show the address arithmetic, including the carry dropped out of the 15-bit page offset. They must also show the circular wraps at both buffer ends, the choice of size/start pair by pointer group, and the load overriding a post-modify. A behavioural model compared on every clock covers these, in directed cases and in a long random run.

// File: rtl/dag_pkg.sv
package dag_pkg;

    localparam int NGRP = 3;

    typedef enum logic [2:0] {
        AM_DPAGE  = 3'd0,
        AM_STACK  = 3'd1,
        AM_IOPAGE = 3'd2,
        AM_INDIR  = 3'd3,
        AM_DUAL   = 3'd4
    } amode_e;

    typedef enum logic [2:0] {
        PM_NONE = 3'd0,
        PM_INC  = 3'd1,
        PM_DEC  = 3'd2,
        PM_CINC = 3'd3,
        PM_CDEC = 3'd4
    } pmod_e;

endpackage

// File: rtl/dag_direct.sv
module dag_direct #(
    parameter int DAW   = 23,
    parameter int PGW   = 8,
    parameter int BASEW = 16,
    parameter int OFFW  = 7,
    parameter int IOW   = 16,
    parameter int IOPGW = 10
) (
    input  logic [2:0]       mode,
    input  logic [OFFW-1:0]  offset,
    input  logic [PGW-1:0]   dp_pg,
    input  logic [BASEW-1:0] dp,
    input  logic [PGW-1:0]   sp_pg,
    input  logic [BASEW-1:0] sp,
    input  logic [IOPGW-1:0] io_pg,
    output logic [DAW-1:0]   dir_addr,
    output logic [IOW-1:0]   io_addr
);
    import dag_pkg::*;

    localparam int DLOW   = DAW - PGW;
    localparam int IOOFFW = IOW - IOPGW;

    logic [BASEW-1:0] base_sel;
    logic [PGW-1:0]   page_sel;
    logic [BASEW-1:0] sum;

    always_comb begin
        if (mode == AM_STACK) begin
            base_sel = sp;
            page_sel = sp_pg;
        end else begin
            base_sel = dp;
            page_sel = dp_pg;
        end
        sum      = base_sel + BASEW'(offset);
        dir_addr = {page_sel, sum[DLOW-1:0]};
        io_addr  = {io_pg, offset[IOOFFW-1:0]};
    end

endmodule

// File: rtl/dag_step.sv
module dag_step #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] cur,
    input  logic [2:0]    kind,
    input  logic [PW-1:0] start,
    input  logic [PW-1:0] size,
    output logic [PW-1:0] nxt
);
    import dag_pkg::*;

    logic [PW-1:0] up;
    logic [PW-1:0] dn;
    logic [PW-1:0] limit;

    always_comb begin
        up    = cur + PW'(1);
        dn    = cur - PW'(1);
        limit = start + size;
        case (kind)
            PM_INC:  nxt = up;
            PM_DEC:  nxt = dn;
            PM_CINC: nxt = (up == limit) ? start : up;
            PM_CDEC: nxt = (cur == start) ? (limit - PW'(1)) : dn;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/dag_ptr_file.sv
module dag_ptr_file #(
    parameter int PW   = 16,
    parameter int NAR  = 8,
    parameter int SELW = 3,
    parameter int LDSW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [LDSW-1:0]   ld_sel,
    input  logic [PW-1:0]     ld_val,
    input  logic              upd_a,
    input  logic [SELW-1:0]   sel_a,
    input  logic [PW-1:0]     nxt_a,
    input  logic              upd_b,
    input  logic [SELW-1:0]   sel_b,
    input  logic [PW-1:0]     nxt_b,
    input  logic              upd_c,
    input  logic [PW-1:0]     nxt_c,
    output logic [(NAR+1)*PW-1:0] ptr_q
);

    for (genvar i = 0; i < NAR; i++) begin : g_ar
        logic [PW-1:0] r;
        always_ff @(posedge clk) begin
            if (rst) begin
                r <= '0;
            end else if (ld_en && ld_sel == LDSW'(i)) begin
                r <= ld_val;
            end else if (upd_a && sel_a == SELW'(i)) begin
                r <= nxt_a;
            end else if (upd_b && sel_b == SELW'(i)) begin
                r <= nxt_b;
            end
        end
        assign ptr_q[i*PW +: PW] = r;
    end

    logic [PW-1:0] coef_r;
    always_ff @(posedge clk) begin
        if (rst) begin
            coef_r <= '0;
        end else if (ld_en && ld_sel == LDSW'(NAR)) begin
            coef_r <= ld_val;
        end else if (upd_c) begin
            coef_r <= nxt_c;
        end
    end
    assign ptr_q[NAR*PW +: PW] = coef_r;

endmodule

// File: rtl/dag_top.sv
module dag_top #(
    parameter int DAW   = 23,
    parameter int PW    = 16,
    parameter int NAR   = 8,
    parameter int PGW   = 8,
    parameter int OFFW  = 7,
    parameter int IOW   = 16,
    parameter int IOPGW = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [2:0]               mode,
    input  logic [OFFW-1:0]          offset,
    input  logic [$clog2(NAR)-1:0]   sel_a,
    input  logic [2:0]               mod_a,
    input  logic [$clog2(NAR)-1:0]   sel_b,
    input  logic [2:0]               mod_b,
    input  logic                     coef_en,
    input  logic [2:0]               mod_c,
    input  logic [PGW-1:0]           dp_pg,
    input  logic [PW-1:0]            dp,
    input  logic [PGW-1:0]           sp_pg,
    input  logic [PW-1:0]            sp,
    input  logic [IOPGW-1:0]         io_pg,
    input  logic [DAW-PW-1:0]        ptr_pg,
    input  logic [3*PW-1:0]          cb_start,
    input  logic [3*PW-1:0]          cb_size,
    input  logic                     ld_en,
    input  logic [$clog2(NAR+1)-1:0] ld_sel,
    input  logic [PW-1:0]            ld_val,
    output logic [DAW-1:0]           addr_a,
    output logic                     a_valid,
    output logic [DAW-1:0]           addr_b,
    output logic                     b_valid,
    output logic [DAW-1:0]           addr_c,
    output logic                     c_valid,
    output logic [IOW-1:0]           io_addr,
    output logic                     io_valid,
    output logic                     conflict,
    output logic [(NAR+1)*PW-1:0]    ptr_flat
);
    import dag_pkg::*;

    localparam int SELW   = $clog2(NAR);
    localparam int LDSW   = $clog2(NAR + 1);
    localparam int NLANE  = 3;
    localparam int HALF   = NAR / 2;

    logic is_dir, is_io, is_ind, is_dual;
    logic [DAW-1:0] dir_addr;
    logic [IOW-1:0] io_raw;

    logic [PW-1:0] lane_cur   [NLANE];
    logic [2:0]    lane_kind  [NLANE];
    logic [1:0]    lane_grp   [NLANE];
    logic [PW-1:0] lane_start [NLANE];
    logic [PW-1:0] lane_size  [NLANE];
    logic [PW-1:0] lane_nxt   [NLANE];

    logic upd_a, upd_b, upd_c;

    always_comb begin
        is_dir  = (mode == AM_DPAGE) || (mode == AM_STACK);
        is_io   = (mode == AM_IOPAGE);
        is_dual = (mode == AM_DUAL);
        is_ind  = (mode == AM_INDIR) || is_dual;
    end

    dag_direct #(
        .DAW(DAW), .PGW(PGW), .BASEW(PW), .OFFW(OFFW), .IOW(IOW), .IOPGW(IOPGW)
    ) u_direct (
        .mode     (mode),
        .offset   (offset),
        .dp_pg    (dp_pg),
        .dp       (dp),
        .sp_pg    (sp_pg),
        .sp       (sp),
        .io_pg    (io_pg),
        .dir_addr (dir_addr),
        .io_addr  (io_raw)
    );

    always_comb begin
        lane_cur[0]  = ptr_flat[int'(sel_a)*PW +: PW];
        lane_cur[1]  = ptr_flat[int'(sel_b)*PW +: PW];
        lane_cur[2]  = ptr_flat[NAR*PW +: PW];
        lane_kind[0] = mod_a;
        lane_kind[1] = mod_b;
        lane_kind[2] = mod_c;
        lane_grp[0]  = (int'(sel_a) >= HALF) ? 2'd1 : 2'd0;
        lane_grp[1]  = (int'(sel_b) >= HALF) ? 2'd1 : 2'd0;
        lane_grp[2]  = 2'd2;
    end

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        always_comb begin
            lane_start[l] = cb_start[int'(lane_grp[l])*PW +: PW];
            lane_size[l]  = cb_size[int'(lane_grp[l])*PW +: PW];
        end
        dag_step #(.PW(PW)) u_step (
            .cur   (lane_cur[l]),
            .kind  (lane_kind[l]),
            .start (lane_start[l]),
            .size  (lane_size[l]),
            .nxt   (lane_nxt[l])
        );
    end

    always_comb begin
        conflict = req_valid && is_dual && (sel_a == sel_b);
        upd_a    = req_valid && is_ind && !conflict;
        upd_b    = req_valid && is_dual && !conflict;
        upd_c    = req_valid && coef_en;

        a_valid  = req_valid && (is_dir || is_ind);
        b_valid  = req_valid && is_dual;
        c_valid  = req_valid && coef_en;
        io_valid = req_valid && is_io;

        if (!req_valid)  addr_a = '0;
        else if (is_dir) addr_a = dir_addr;
        else if (is_ind) addr_a = {ptr_pg, lane_cur[0]};
        else             addr_a = '0;

        addr_b  = b_valid  ? {ptr_pg, lane_cur[1]} : '0;
        addr_c  = c_valid  ? {ptr_pg, lane_cur[2]} : '0;
        io_addr = io_valid ? io_raw : '0;
    end

    dag_ptr_file #(
        .PW(PW), .NAR(NAR), .SELW(SELW), .LDSW(LDSW)
    ) u_ptrs (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (ld_en),
        .ld_sel (ld_sel),
        .ld_val (ld_val),
        .upd_a  (upd_a),
        .sel_a  (sel_a),
        .nxt_a  (lane_nxt[0]),
        .upd_b  (upd_b),
        .sel_b  (sel_b),
        .nxt_b  (lane_nxt[1]),
        .upd_c  (upd_c),
        .nxt_c  (lane_nxt[2]),
        .ptr_q  (ptr_flat)
    );

endmodule

// File: rtl/dag_chk.sv
module dag_chk #(
    parameter int PW   = 16,
    parameter int NAR  = 8,
    parameter int SELW = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic [2:0]            mode,
    input logic [SELW-1:0]       sel_a,
    input logic [SELW-1:0]       sel_b,
    input logic                  ld_en,
    input logic                  a_valid,
    input logic                  b_valid,
    input logic                  io_valid,
    input logic                  conflict,
    input logic [(NAR+1)*PW-1:0] ptr_flat
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ptr_flat == '0);

    // R12
    conflict_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == 3'd4 && sel_a == sel_b) |-> conflict);

    // R12
    conflict_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (conflict && !ld_en) |=>
        ptr_flat[int'($past(sel_a))*PW +: PW] == $past(ptr_flat[int'(sel_a)*PW +: PW]));

    // R6
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !ld_en) |=> $stable(ptr_flat));

    // R4
    io_excl_chk: assert property (@(posedge clk) disable iff (rst)
        io_valid |-> (!a_valid && !b_valid));

    // R10
    dual_pair_chk: assert property (@(posedge clk) disable iff (rst)
        b_valid |-> a_valid);

endmodule

bind dag_top dag_chk #(.PW(PW), .NAR(NAR), .SELW($clog2(NAR))) u_dag_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .mode      (mode),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .ld_en     (ld_en),
    .a_valid   (a_valid),
    .b_valid   (b_valid),
    .io_valid  (io_valid),
    .conflict  (conflict),
    .ptr_flat  (ptr_flat)
);

// File: tb/test_dag_top.sv
module test_dag_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        req_valid = 0;
    logic [2:0]  mode = 0;
    logic [6:0]  offset = 0;
    logic [2:0]  sel_a = 0, mod_a = 0, sel_b = 0, mod_b = 0, mod_c = 0;
    logic        coef_en = 0;
    logic [7:0]  dp_pg = 0, sp_pg = 0;
    logic [15:0] dp = 0, sp = 0;
    logic [9:0]  io_pg = 0;
    logic [6:0]  ptr_pg = 0;
    logic [47:0] cb_start = 0, cb_size = 0;
    logic        ld_en = 0;
    logic [3:0]  ld_sel = 0;
    logic [15:0] ld_val = 0;

    logic [22:0]  addr_a, addr_b, addr_c;
    logic         a_valid, b_valid, c_valid, io_valid, conflict;
    logic [15:0]  io_addr;
    logic [143:0] ptr_flat;

    dag_top i_dag_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode), .offset(offset),
        .sel_a(sel_a), .mod_a(mod_a), .sel_b(sel_b), .mod_b(mod_b),
        .coef_en(coef_en), .mod_c(mod_c), .dp_pg(dp_pg), .dp(dp),
        .sp_pg(sp_pg), .sp(sp), .io_pg(io_pg), .ptr_pg(ptr_pg),
        .cb_start(cb_start), .cb_size(cb_size), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_val(ld_val), .addr_a(addr_a), .a_valid(a_valid), .addr_b(addr_b),
        .b_valid(b_valid), .addr_c(addr_c), .c_valid(c_valid), .io_addr(io_addr),
        .io_valid(io_valid), .conflict(conflict), .ptr_flat(ptr_flat)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int model [9];
    string tag = "R1";

    task automatic chk(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic int step(int cur, int k, int st, int sz);
        int n;
        case (k)
            1: return (cur + 1) & 16'hFFFF;
            2: return (cur - 1) & 16'hFFFF;
            3: begin
                n = (cur + 1) & 16'hFFFF;
                return (n == ((st + sz) & 16'hFFFF)) ? st : n;
            end
            4: return (cur == st) ? ((st + sz - 1) & 16'hFFFF) : ((cur - 1) & 16'hFFFF);
            default: return cur;
        endcase
    endfunction

    function automatic int gstart(int g); return int'(cb_start[g*16 +: 16]); endfunction
    function automatic int gsize(int g);  return int'(cb_size[g*16 +: 16]);  endfunction

    task automatic check_ptrs(string req);
        for (int i = 0; i < 9; i++)
            chk(req, $sformatf("ptr%0d", i), int'(ptr_flat[i*16 +: 16]), model[i]);
    endtask

    // Called just after a falling edge with inputs set.
    task automatic run_cycle();
        int ea, eb, ec, eio, dual, ind, cf, na, nb, nc;
        bit av, bv, cv, iov;
        #1;
        dual = (mode == 4);
        ind  = (mode == 3) || dual;
        av   = req_valid && (mode <= 1 || ind);
        bv   = req_valid && dual;
        cv   = req_valid && coef_en;
        iov  = req_valid && (mode == 2);
        cf   = req_valid && dual && (sel_a == sel_b);
        ea = 0;
        if (req_valid && mode == 0) ea = (int'(dp_pg) << 15) | ((int'(dp) + int'(offset)) & 32'h7FFF);
        else if (req_valid && mode == 1) ea = (int'(sp_pg) << 15) | ((int'(sp) + int'(offset)) & 32'h7FFF);
        else if (av) ea = (int'(ptr_pg) << 16) | model[sel_a];
        eb  = bv ? ((int'(ptr_pg) << 16) | model[sel_b]) : 0;
        ec  = cv ? ((int'(ptr_pg) << 16) | model[8]) : 0;
        eio = iov ? ((int'(io_pg) << 6) | (int'(offset) & 63)) : 0;
        chk(tag, "a_valid", int'(a_valid), int'(av));
        chk(tag, "addr_a", int'(addr_a), ea);
        chk(tag, "b_valid", int'(b_valid), int'(bv));
        chk(tag, "addr_b", int'(addr_b), eb);
        chk(tag, "c_valid", int'(c_valid), int'(cv));
        chk(tag, "addr_c", int'(addr_c), ec);
        chk(tag, "io_valid", int'(io_valid), int'(iov));
        chk(tag, "io_addr", int'(io_addr), eio);
        chk(tag, "conflict", int'(conflict), cf);
        na = step(model[sel_a], mod_a, gstart(sel_a >= 4), gsize(sel_a >= 4));
        nb = step(model[sel_b], mod_b, gstart(sel_b >= 4), gsize(sel_b >= 4));
        nc = step(model[8], mod_c, gstart(2), gsize(2));
        @(posedge clk);
        if (req_valid && ind && !cf) model[sel_a] = na;
        if (req_valid && dual && !cf) model[sel_b] = nb;
        if (cv) model[8] = nc;
        if (ld_en && ld_sel == 8) model[8] = int'(ld_val);
        else if (ld_en && ld_sel < 8) model[ld_sel] = int'(ld_val);
        @(negedge clk);
        check_ptrs(tag);
    endtask

    task automatic idle();
        req_valid = 0; mode = 0; offset = 0; coef_en = 0;
        mod_a = 0; mod_b = 0; mod_c = 0; ld_en = 0;
    endtask

    task automatic load(int s, int v);
        idle(); ld_en = 1; ld_sel = 4'(s); ld_val = 16'(v);
        run_cycle();
        ld_en = 0;
    endtask

    task automatic ind1(int s, int k);
        idle(); req_valid = 1; mode = 3; sel_a = 3'(s); mod_a = 3'(k);
        run_cycle();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 9; i++) model[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        tag = "R1";
        check_ptrs("R1");
        run_cycle();

        tag = "R13";
        for (int i = 0; i < 9; i++) load(i, 16'h1000 + i * 16'h0111);
        load(12, 16'hDEAD);

        idle(); dp_pg = 8'hA5; dp = 16'h7FF0; sp_pg = 8'h3C; sp = 16'hFFFE; io_pg = 10'h2B7;
        ptr_pg = 7'h55;
        tag = "R2"; req_valid = 1; mode = 0; offset = 7'h20; run_cycle();
        tag = "R3"; req_valid = 1; mode = 1; offset = 7'h05; run_cycle();
        tag = "R4"; req_valid = 1; mode = 2; offset = 7'h7F; run_cycle();
        tag = "R5"; idle(); req_valid = 1; mode = 6; run_cycle();
        idle(); req_valid = 0; mode = 3; run_cycle();

        tag = "R5"; ind1(2, 0);
        tag = "R6"; ind1(2, 1); ind1(3, 2); load(0, 0); ind1(0, 2); ind1(0, 1);

        cb_start = {16'h0300, 16'h0200, 16'h0100};
        cb_size  = {16'd5, 16'd3, 16'd4};
        tag = "R7"; load(1, 16'h0102); ind1(1, 3); ind1(1, 3);
        tag = "R8"; ind1(1, 4); ind1(1, 4);
        tag = "R9"; load(5, 16'h0201); ind1(5, 3); ind1(5, 3); ind1(5, 4);
        load(8, 16'h0304);
        tag = "R11"; idle(); req_valid = 1; mode = 0; coef_en = 1; mod_c = 3; run_cycle();
        tag = "R10"; idle(); req_valid = 1; mode = 4; sel_a = 1; mod_a = 3; sel_b = 6; mod_b = 2;
        coef_en = 1; mod_c = 4; run_cycle();
        tag = "R12"; idle(); req_valid = 1; mode = 4; sel_a = 6; sel_b = 6; mod_a = 1; mod_b = 1;
        run_cycle();
        tag = "R13"; idle(); req_valid = 1; mode = 3; sel_a = 4; mod_a = 1;
        ld_en = 1; ld_sel = 4; ld_val = 16'h4444; run_cycle();

        for (int n = 0; n < 3000; n++) begin
            idle();
            req_valid = ($urandom_range(0, 9) != 0);
            mode    = 3'($urandom_range(0, 7));
            offset  = 7'($urandom);
            sel_a   = 3'($urandom); sel_b = 3'($urandom);
            mod_a   = 3'($urandom); mod_b = 3'($urandom); mod_c = 3'($urandom);
            coef_en = 1'($urandom);
            dp = 16'($urandom); sp = 16'($urandom); dp_pg = 8'($urandom);
            sp_pg = 8'($urandom); io_pg = 10'($urandom); ptr_pg = 7'($urandom);
            ld_en   = ($urandom_range(0, 7) == 0);
            ld_sel  = 4'($urandom);
            ld_val  = 16'h0100 + 16'($urandom_range(0, 8));
            if (n % 500 == 0) cb_size = {16'($urandom_range(1, 9)), 16'($urandom_range(1, 9)), 16'($urandom_range(1, 9))};
            case (mode)
                0: tag = "R2";
                1: tag = "R3";
                2: tag = "R4";
                4: tag = "R10";
                default: tag = "R5";
            endcase
            run_cycle();
        end

        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule